// File: doc/BRIEF.md
# DTMF Digit Serial Readout Port

This block sits behind a tone-pair decoder. When the decoder presents a 4-bit digit code with its valid flag raised, an external controller can fetch the digit one bit at a time. It does so by pulsing an acknowledge line. The first acknowledge rising edge latches the code into a shift register and puts the lowest bit on the serial output. Each later rising edge moves to the next bit. The acknowledge line may come from another clock domain, so it passes through a synchroniser before its edges are detected.

The serial output pin is shared. When no digit bit is being presented, it carries a call-progress cadence bit, which is the tone envelope supplied by the detector. While power-down is asserted, the pin is forced low. Power-down also drops any readout in progress.

The controller is a four-state machine:
- `ST_IDLE`: shows cadence and waits for a valid rising edge.
- `ST_ARMED`: shows cadence. The valid flag is high and no bit has been sent yet.
- `ST_SHIFT`: shows digit bits 0 to 2.
- `ST_LAST`: shows bit 3.

The transitions are:
- `ST_IDLE` goes to `ST_ARMED` on a valid rising edge.
- `ST_ARMED` goes to `ST_SHIFT` on an acknowledge edge, which also captures the code.
- `ST_SHIFT` stays in `ST_SHIFT` on an acknowledge edge while the shift count is below the digit width minus one. At that count, the acknowledge edge moves it to `ST_LAST`.
- `ST_LAST` goes to `ST_IDLE` on an acknowledge edge or when valid drops.
- `ST_ARMED` and `ST_SHIFT` go to `ST_IDLE` when valid drops.
- Every state goes to `ST_IDLE` on reset or power-down.

Top module: `dtmf_sd_readout`

## Requirements
- R1: After synchronous reset, no readout is in progress and `sd_o` equals `cadence_i`.
- R2: While no digit bit is presented and power-down is low, `sd_o` follows `cadence_i` combinationally.
- R3: While `pwr_down_i` is high, `sd_o` is 0 and acknowledge pulses have no effect. After release, the port is idle and shows cadence until a new valid rising edge.
- R4: Acknowledge pulses received before a low-to-high transition of `valid_i` are ignored. Once a readout has started, the first bit shown is still bit 0.
- R5: The first acknowledge rising edge after arming captures `digit_i`. Changes to `digit_i` after that edge do not alter the bits shifted out.
- R6: Digit bits appear least-significant first, one per acknowledge rising edge. Each bit stays on `sd_o` until the next rising edge.
- R7: After the fourth bit, `sd_o` keeps that bit while `valid_i` stays high and no new acknowledge edge arrives. The next acknowledge edge returns `sd_o` to cadence.
- R8: The readout does not rearm while `valid_i` stays high. Acknowledge pulses after the fourth bit leave `sd_o` on cadence.
- R9: If `valid_i` falls during a readout, the readout is abandoned and `sd_o` returns to cadence.
- R10: `ack_i` passes a two-flop synchroniser. `sd_o` changes at the third rising clock edge after `ack_i` goes high, counting the first edge that samples it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_down_i | input | 1 | Power-down: forces `sd_o` low and clears the readout |
| digit_i | input | 4 | Decoded tone-pair code, one of 16 values |
| valid_i | input | 1 | Steering flag from the decoder; a rising edge arms a readout |
| cadence_i | input | 1 | Call-progress envelope bit |
| ack_i | input | 1 | Asynchronous acknowledge pulses from the controller; idles low |
| sd_o | output | 1 | Shared serial digit / cadence output |

## Verification
The bench checks random digit codes shifted out over full four-pulse readouts. In some readouts it changes `digit_i` after the capture edge, which separates a design that latches the code from one that reads the input live. It uses cadence values that differ from the expected bit, so a wrong choice between the shared output paths cannot hide. Directed cases cover:
- pulses before arming
- a fifth pulse with valid held high
- valid falling mid-readout
- power-down during a readout
- sampling one cycle before and one cycle at the expected output change

These separate wrong bit order, missing rearm gating and wrong synchroniser latency.

// File: rtl/dtmf_rd_pkg.sv
package dtmf_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2,
        ST_LAST  = 2'd3
    } rd_state_e;
endpackage

// File: rtl/dtmf_ack_sync.sv
module dtmf_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            prev_q <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        rise_o = chain_q[STAGES-1] & ~prev_q;
    end

    // R10
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/dtmf_rd_fsm.sv
module dtmf_rd_fsm
    import dtmf_rd_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_down_i,
    input  logic               valid_i,
    input  logic               ack_rise_i,
    input  logic [DIGIT_W-1:0] digit_i,
    output logic               show_o,
    output logic               bit_o
);
    localparam int CNT_W = $clog2(DIGIT_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIGIT_W - 1);

    rd_state_e          state_q, state_d;
    logic [DIGIT_W-1:0] sreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               valid_q;
    logic               valid_rise;
    logic               load, shift;

    assign valid_rise = valid_i & ~valid_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b0;
        end else if (pwr_down_i) begin
            state_q <= ST_IDLE;
            valid_q <= valid_i;
        end else begin
            state_q <= state_d;
            valid_q <= valid_i;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        shift   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (valid_rise) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!valid_i) begin
                    state_d = ST_IDLE;
                end else if (ack_rise_i) begin
                    state_d = ST_SHIFT;
                    load    = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (!valid_i) begin
                    state_d = ST_IDLE;
                end else if (ack_rise_i) begin
                    shift = 1'b1;
                    if (cnt_q == CNT_LAST) state_d = ST_LAST;
                end
            end
            ST_LAST: begin
                if (!valid_i || ack_rise_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // shift register and bit counter
    always_ff @(posedge clk) begin
        if (rst || pwr_down_i) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            sreg_q <= digit_i;
            cnt_q  <= CNT_W'(1);
        end else if (shift) begin
            sreg_q <= sreg_q >> 1;
            cnt_q  <= cnt_q + 1'b1;
        end else if (state_d == ST_IDLE) begin
            cnt_q  <= '0;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_SHIFT, ST_LAST: show_o = 1'b1;
            default:           show_o = 1'b0;
        endcase
        bit_o = sreg_q[0];
    end

    // R4
    idle_no_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> (state_q == ST_IDLE || state_q == ST_ARMED));
    // R5
    load_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED && valid_i && ack_rise_i && !pwr_down_i)
        |=> (state_q == ST_SHIFT && cnt_q == CNT_W'(1)));
    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DIGIT_W));
    // R7
    last_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LAST && ack_rise_i) |=> (state_q == ST_IDLE));
    // R3
    pd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down_i |=> (state_q == ST_IDLE && cnt_q == '0));
    // R9
    drop_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && state_q != ST_IDLE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/dtmf_sd_mux.sv
module dtmf_sd_mux (
    input  logic pwr_down_i,
    input  logic show_i,
    input  logic bit_i,
    input  logic cadence_i,
    output logic sd_o
);
    always_comb begin
        if (pwr_down_i)  sd_o = 1'b0;
        else if (show_i) sd_o = bit_i;
        else             sd_o = cadence_i;
    end
endmodule

// File: rtl/dtmf_sd_readout.sv
module dtmf_sd_readout #(
    parameter int DIGIT_W     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_down_i,
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic               valid_i,
    input  logic               cadence_i,
    input  logic               ack_i,
    output logic               sd_o
);
    logic ack_rise;
    logic show;
    logic bit_out;

    dtmf_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ack_i),
        .rise_o  (ack_rise)
    );

    dtmf_rd_fsm #(.DIGIT_W(DIGIT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pwr_down_i (pwr_down_i),
        .valid_i    (valid_i),
        .ack_rise_i (ack_rise),
        .digit_i    (digit_i),
        .show_o     (show),
        .bit_o      (bit_out)
    );

    dtmf_sd_mux u_mux (
        .pwr_down_i (pwr_down_i),
        .show_i     (show),
        .bit_i      (bit_out),
        .cadence_i  (cadence_i),
        .sd_o       (sd_o)
    );

    // R2
    cadence_path_chk: assert property (@(posedge clk) disable iff (rst)
        (!pwr_down_i && !show) |-> (sd_o == cadence_i));
endmodule

// File: tb/sim_dtmf_sd_readout.sv
module sim_dtmf_sd_readout;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_down_i = 1'b0;
    logic [3:0] digit_i = 4'd0;
    logic       valid_i = 1'b0;
    logic       cadence_i = 1'b0;
    logic       ack_i = 1'b0;
    logic       sd_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtmf_sd_readout u0 (
        .clk        (clk),
        .rst        (rst),
        .pwr_down_i (pwr_down_i),
        .digit_i    (digit_i),
        .valid_i    (valid_i),
        .cadence_i  (cadence_i),
        .ack_i      (ack_i),
        .sd_o       (sd_o)
    );

    function automatic logic exp_bit(logic [3:0] code, int idx);
        return code[idx];
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // pulse ack, check the value during the high phase and after release
    task automatic pulse(string req, logic exp);
        ack_i = 1'b1;
        tick(4);
        check(req, sd_o, exp);
        ack_i = 1'b0;
        tick(4);
        check(req, sd_o, exp);
    endtask

    task automatic arm();
        valid_i = 1'b0;
        tick(2);
        valid_i = 1'b1;
        tick(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state shows cadence
        cadence_i = 1'b1; #1; check("R1", sd_o, 1'b1);
        cadence_i = 1'b0; #1; check("R1", sd_o, 1'b0);

        // R4 pulse with valid low is ignored
        cadence_i = 1'b1;
        digit_i   = 4'b0000;
        pulse("R4", 1'b1);

        // arm, then R10 latency on first bit (bit0 = 0, cadence = 1)
        digit_i = 4'b1010;
        arm();
        ack_i = 1'b1;
        tick(2);
        check("R10", sd_o, 1'b1);
        tick(1);
        check("R10", sd_o, 1'b0);
        check("R4", sd_o, exp_bit(4'b1010, 0));
        ack_i = 1'b0;
        tick(4);
        // R5 input change after capture has no effect
        digit_i = 4'b0101;
        pulse("R5", 1'b1);
        pulse("R6", 1'b0);
        cadence_i = 1'b0;
        pulse("R6", 1'b1);
        // R7 fourth bit held
        tick(5);
        check("R7", sd_o, 1'b1);
        // R7 next pulse returns to cadence
        pulse("R7", 1'b0);
        cadence_i = 1'b1; #1;
        check("R7", sd_o, 1'b1);
        // R8 no rearm while valid stays high
        cadence_i = 1'b0;
        pulse("R8", 1'b0);
        cadence_i = 1'b1;
        pulse("R8", 1'b1);

        // R9 valid falls mid-readout
        digit_i = 4'b0011;
        cadence_i = 1'b0;
        arm();
        pulse("R9", 1'b1);
        valid_i = 1'b0;
        tick(2);
        check("R9", sd_o, 1'b0);
        pulse("R4", 1'b0);

        // R3 power-down during readout
        digit_i = 4'b1111;
        arm();
        pulse("R3", 1'b1);
        cadence_i = 1'b1;
        pwr_down_i = 1'b1;
        tick(2);
        check("R3", sd_o, 1'b0);
        pulse("R3", 1'b0);
        pwr_down_i = 1'b0;
        tick(2);
        check("R3", sd_o, 1'b1);
        cadence_i = 1'b0;
        pulse("R3", 1'b0);

        // R2 cadence passthrough while idle
        for (int k = 0; k < 8; k++) begin
            logic c;
            c = 1'($urandom);
            cadence_i = c;
            #1;
            check("R2", sd_o, c);
            tick(1);
        end

        // random readouts
        for (int it = 0; it < 24; it++) begin
            logic [3:0] code;
            code = 4'($urandom);
            digit_i = code;
            arm();
            for (int b = 0; b < 4; b++) begin
                cadence_i = ~exp_bit(code, b);
                pulse("R6", exp_bit(code, b));
                if (b == 0 && ($urandom % 2) == 1) digit_i = ~code;
            end
            cadence_i = ~exp_bit(code, 3);
            if (($urandom % 2) == 1) begin
                pulse("R7", cadence_i);
            end else begin
                valid_i = 1'b0;
                tick(2);
                check("R9", sd_o, cadence_i);
            end
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule